// File: doc/BRIEF.md
# ADC result and control register front end

This block sits between an 8-bit CPU bus and the conversion engine of an eight-input analog-to-digital converter. It keeps four 16-bit result registers and one 8-bit control/status byte. When the engine reports that a conversion has finished, it presents a 10-bit result and a 3-bit input number. The block stores that result, left-justified, in the register that the two low bits of the input number select, so inputs 0 and 4 share register A and inputs 3 and 7 share register D.

The CPU reads the upper byte of a result directly. The same read copies the lower byte into a holding latch, and a later low-byte read returns the latch. The two halves of a result therefore always belong to the same conversion. The control byte drives the start, scan, clock-select and input-select lines of the engine. Its done flag, together with the interrupt enable, drives an interrupt request. The done flag is cleared by writing 0 to it. Reset, standby and module-stop each clear every register and the holding latch on the next clock edge.

Bus map: addresses 0/1 are the high/low bytes of result A, 2/3 of B, 4/5 of C and 6/7 of D. Address 8 is the control/status byte. Addresses 9 to 15 read as 0 and ignore writes.

Top module: `adc_reg_front`

## Requirements
- R1: The four result registers are read-only. A bus write to addresses 0 to 7 changes no result and does not change the holding latch.
- R2: A 10-bit result v is returned as high byte v[9:2] and low byte {v[1:0], 6'b000000}. Bits 5..0 of a low-byte read are always 0.
- R3: A completion strobe with input number c writes its result into register c[1:0] (A=0 to D=3). Bit c[2] has no effect on which register is written.
- R4: A read of a high-byte address returns the stored high byte and copies that register's low byte into the holding latch. A read of any low-byte address returns the latch, even if a new conversion has landed in between.
- R5: Address 8 reads and writes the control byte with bit 7 done, bit 6 interrupt enable, bit 5 start, bit 4 scan, bit 3 clock select and bits 2..0 input select. The engine outputs follow the stored bits.
- R6: Writing 0 to bit 7 clears the done flag. Writing 1 to bit 7 leaves the flag unchanged.
- R7: Reset, standby and module-stop each clear all result registers, the control byte, the holding latch, the read data and the interrupt request at the next clock edge.
- R8: The done flag is set by a completion strobe while scan is 0, or by a scan-pass-end strobe. This set wins over a CPU clear in the same cycle.
- R9: The interrupt request is 1 exactly when the done flag and the interrupt enable are both 1.
- R10: In single mode (scan=0), a completion strobe clears start, and this clear wins over a same-cycle write. In scan mode, start stays set until the CPU writes 0 to it.
- R11: The read data changes only on the clock edge that samples a read strobe, so it is valid in the following cycle and holds otherwise. Addresses 9 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby | input | 1 | Standby: synchronous clear of all state |
| mstop | input | 1 | Module stop: synchronous clear of all state |
| bus_addr | input | 4 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| eng_done | input | 1 | Conversion-complete strobe |
| eng_pass_end | input | 1 | Scan-pass-complete strobe |
| eng_result | input | 10 | Conversion result |
| eng_chan | input | 3 | Input number of the result |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | Start bit to engine |
| eng_scan | output | 1 | Scan mode to engine |
| eng_cks | output | 1 | Clock select to engine |
| eng_chsel | output | 3 | Input select to engine |

## Verification
Several properties are checked on every cycle:
- The interrupt request always tracks the done flag and the enable.
- A written 1 never sets the flag.
- A hardware set always lands, even against a CPU clear.
- Single-mode completion drops start, and scan mode holds start.
- Read data holds between strobes, and low-byte reads carry zero padding.
- Standby or module-stop empties the block.

Some behaviours can only be shown by the bench scenarios. These are the routing of group-1 inputs onto the shared registers, the coherence of split reads when a conversion lands between the two halves, and the refusal of writes to result addresses.

// File: rtl/adc_front_pkg.sv
package adc_front_pkg;
  localparam int DATA_W = 8;
  localparam int CH_W   = 3;

  typedef struct packed {
    logic            done;
    logic            ie;
    logic            start;
    logic            scan;
    logic            cks;
    logic [CH_W-1:0] chsel;
  } ctl_t;
endpackage

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int RES_W = 10,
  parameter int N_RES = 4,
  localparam int IDX_W = $clog2(N_RES)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RES_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_val
);
  logic [RES_W-1:0] slot_q [N_RES];

  for (genvar g = 0; g < N_RES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (clr)
        slot_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        slot_q[g] <= wr_val;
    end
  end

  assign rd_val = slot_q[rd_idx];
endmodule

// File: rtl/adc_ctl_status.sv
module adc_ctl_status
  import adc_front_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              conv_done,
  input  logic              pass_end,
  output ctl_t              ctl_q,
  output logic              irq_q
);
  ctl_t ctl_n;
  logic hw_set, auto_stop;

  assign auto_stop = conv_done && !ctl_q.scan;
  assign hw_set    = auto_stop || pass_end;

  always_comb begin
    ctl_n = ctl_q;
    if (wr_en) begin
      ctl_n       = ctl_t'(wdata);
      ctl_n.done  = ctl_q.done & wdata[DATA_W-1];
    end
    if (auto_stop) ctl_n.start = 1'b0;
    if (hw_set)    ctl_n.done  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      irq_q <= ctl_n.done & ctl_n.ie;
    end
  end

  p_irq_track_r9: assert property (@(posedge clk) disable iff (clr)
    irq_q == (ctl_q.done & ctl_q.ie));
  p_w1_no_set_r6: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wdata[DATA_W-1] && !ctl_q.done && !hw_set) |=> !ctl_q.done);
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (clr)
    hw_set |=> ctl_q.done);
  p_single_stop_r10: assert property (@(posedge clk) disable iff (clr)
    auto_stop |=> !ctl_q.start);
  p_scan_hold_r10: assert property (@(posedge clk) disable iff (clr)
    (ctl_q.scan && ctl_q.start && !wr_en) |=> ctl_q.start);
endmodule

// File: rtl/adc_read_port.sv
module adc_read_port
  import adc_front_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int ADDR_W = 4,
  localparam int LO_W  = RES_W - DATA_W,
  localparam int PAD_W = DATA_W - LO_W
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [RES_W-1:0]  res_val,
  input  logic [DATA_W-1:0] ctl_byte,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] hi_byte, lo_byte;
  logic              is_ctl_space, is_ctl;

  assign hi_byte      = res_val[RES_W-1 -: DATA_W];
  assign lo_byte      = {res_val[LO_W-1:0], {PAD_W{1'b0}}};
  assign is_ctl_space = addr[ADDR_W-1];
  assign is_ctl       = is_ctl_space && (addr[ADDR_W-2:0] == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      rdata_q <= '0;
      hold_q  <= '0;
    end else if (rd_en) begin
      if (is_ctl_space)
        rdata_q <= is_ctl ? ctl_byte : '0;
      else if (addr[0])
        rdata_q <= hold_q;
      else begin
        rdata_q <= hi_byte;
        hold_q  <= lo_byte;
      end
    end
  end

  p_lo_pad_r2: assert property (@(posedge clk) disable iff (clr)
    (rd_en && !is_ctl_space && addr[0]) |=> (rdata_q[PAD_W-1:0] == '0));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (clr)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/adc_reg_front.sv
module adc_reg_front
  import adc_front_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int N_RES = 4,
  localparam int IDX_W  = $clog2(N_RES),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stby,
  input  logic              mstop,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_done,
  input  logic              eng_pass_end,
  input  logic [RES_W-1:0]  eng_result,
  input  logic [CH_W-1:0]   eng_chan,
  output logic              irq,
  output logic              eng_start,
  output logic              eng_scan,
  output logic              eng_cks,
  output logic [CH_W-1:0]   eng_chsel
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(1) << (ADDR_W - 1);

  logic             clr;
  logic             ctl_wr;
  ctl_t             ctl_q;
  logic [RES_W-1:0] res_val;

  assign clr    = rst | stby | mstop;
  assign ctl_wr = bus_wr && (bus_addr == CTL_ADDR);

  adc_result_bank #(.RES_W(RES_W), .N_RES(N_RES)) u_bank (
    .clk    (clk),
    .clr    (clr),
    .wr_en  (eng_done),
    .wr_idx (eng_chan[IDX_W-1:0]),
    .wr_val (eng_result),
    .rd_idx (bus_addr[IDX_W:1]),
    .rd_val (res_val)
  );

  adc_ctl_status u_ctl (
    .clk       (clk),
    .clr       (clr),
    .wr_en     (ctl_wr),
    .wdata     (bus_wdata),
    .conv_done (eng_done),
    .pass_end  (eng_pass_end),
    .ctl_q     (ctl_q),
    .irq_q     (irq)
  );

  adc_read_port #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .clr      (clr),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .res_val  (res_val),
    .ctl_byte (DATA_W'(ctl_q)),
    .rdata_q  (bus_rdata)
  );

  assign eng_start = ctl_q.start;
  assign eng_scan  = ctl_q.scan;
  assign eng_cks   = ctl_q.cks;
  assign eng_chsel = ctl_q.chsel;

  p_sleep_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (stby || mstop) |=> (bus_rdata == '0 && !irq && !eng_start && !eng_scan));
endmodule

// File: tb/adc_reg_front_bench.sv
module adc_reg_front_bench;
  logic       clk = 0, rst = 1, stby = 0, mstop = 0;
  logic [3:0] bus_addr = 0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       eng_done = 0, eng_pass_end = 0;
  logic [9:0] eng_result = 0;
  logic [2:0] eng_chan = 0;
  logic       irq, eng_start, eng_scan, eng_cks;
  logic [2:0] eng_chsel;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  adc_reg_front u_adc_reg_front (.*);

  // reference state
  logic [9:0] m_res [4];
  logic [7:0] m_hold, m_rdata;
  logic       m_done, m_ie, m_start, m_scan, m_cks;
  logic [2:0] m_ch;

  function automatic logic [7:0] ctl_byte();
    return {m_done, m_ie, m_start, m_scan, m_cks, m_ch};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) m_res[i] = '0;
    m_hold = 0; m_rdata = 0;
    {m_done, m_ie, m_start, m_scan, m_cks, m_ch} = '0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " rdata"}, 32'(bus_rdata), 32'(m_rdata));
    check({tag, " irq R9"}, 32'(irq), 32'(m_done & m_ie));
    check({tag, " ctl-out R5"}, 32'({eng_start, eng_scan, eng_cks, eng_chsel}),
          32'({m_start, m_scan, m_cks, m_ch}));
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(string tag, logic rd, logic wr, logic [3:0] a, logic [7:0] wd,
                      logic cd, logic pe, logic [9:0] rv, logic [2:0] ch,
                      logic sb, logic ms);
    logic set_f, stop_f;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    eng_done = cd; eng_pass_end = pe; eng_result = rv; eng_chan = ch;
    stby = sb; mstop = ms;
    @(posedge clk);
    if (sb || ms) model_clear();
    else begin
      if (rd) begin
        if (a[3]) m_rdata = (a[2:0] == 0) ? ctl_byte() : 8'h00;
        else if (a[0]) m_rdata = m_hold;
        else begin
          m_rdata = m_res[a[2:1]][9:2];
          m_hold  = {m_res[a[2:1]][1:0], 6'b0};
        end
      end
      stop_f = cd && !m_scan;
      set_f  = stop_f || pe;
      if (wr && a == 4'd8) begin
        m_done = m_done & wd[7];
        {m_ie, m_start, m_scan, m_cks, m_ch} = wd[6:0];
      end
      if (stop_f) m_start = 0;
      if (set_f)  m_done  = 1;
      if (cd) m_res[ch[1:0]] = rv;
    end
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; eng_done = 0; eng_pass_end = 0; stby = 0; mstop = 0;
    compare_all(tag);
  endtask

  task automatic rd(string tag, logic [3:0] a);
    step(tag, 1, 0, a, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(string tag, logic [3:0] a, logic [7:0] d);
    step(tag, 0, 1, a, d, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic conv(string tag, logic [2:0] c, logic [9:0] v);
    step(tag, 0, 0, 0, 0, 1, 0, v, c, 0, 0);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    compare_all("reset R7");

    wr("ctl write R5", 4'd8, 8'h5B);
    rd("ctl read R5", 4'd8);
    check("ctl byte R5", 32'(bus_rdata), 32'h5B);

    conv("group1 conv R3", 3'd5, 10'h2D7);
    rd("B hi R3", 4'd2);
    check("B hi value R2", 32'(bus_rdata), 32'hB5);
    rd("B lo R2", 4'd3);
    check("B lo value R2", 32'(bus_rdata), 32'hC0);
    rd("A hi untouched R3", 4'd0);
    check("A hi zero R3", 32'(bus_rdata), 32'h00);

    conv("A load R4", 3'd0, 10'h3C1);
    rd("A hi R4", 4'd0);
    conv("A overwrite R4", 3'd4, 10'h002);
    rd("A lo coherent R4", 4'd1);
    check("A lo old half R4", 32'(bus_rdata), 32'h40);

    wr("result write R1", 4'd0, 8'hFF);
    wr("result write lo R1", 4'd1, 8'hFF);
    rd("A hi after write R1", 4'd0);
    check("A hi unchanged R1", 32'(bus_rdata), 32'h00);

    wr("ie single R6", 4'd8, 8'h60);
    conv("single done R10", 3'd2, 10'h155);
    check("start cleared R10", 32'(eng_start), 32'd0);
    check("irq up R9", 32'(irq), 32'd1);
    wr("write 1 to done R6", 4'd8, 8'hC0);
    check("done kept R6", 32'(irq), 32'd1);
    wr("write 0 to done R6", 4'd8, 8'h40);
    check("done cleared R6", 32'(irq), 32'd0);

    step("clear vs set R8", 0, 1, 4'd8, 8'h40, 0, 1, 0, 0, 0, 0);
    check("hw set wins R8", 32'(irq), 32'd1);

    wr("scan start R10", 4'd8, 8'h70);
    conv("scan conv R10", 3'd6, 10'h0AA);
    check("scan start held R10", 32'(eng_start), 32'd1);
    check("scan no done R8", 32'(irq), 32'd0);
    step("pass end R8", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    check("pass end done R8", 32'(irq), 32'd1);

    rd("unmapped R11", 4'd9);
    check("unmapped zero R11", 32'(bus_rdata), 32'd0);

    step("standby R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    rd("after standby R7", 4'd6);
    check("D zero R7", 32'(bus_rdata), 32'd0);
    wr("refill R7", 4'd8, 8'h7F);
    conv("refill conv R7", 3'd1, 10'h3FF);
    rd("refill hold R7", 4'd2);
    step("mstop R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    rd("hold after mstop R7", 4'd3);
    check("hold zero R7", 32'(bus_rdata), 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic       r, w;
      a = $urandom_range(0, 3) == 0 ? 4'd8 : 4'($urandom_range(0, 15));
      r = $urandom_range(0, 1);
      w = !r && ($urandom_range(0, 2) == 0);
      step("random R11", r, w, a, 8'($urandom),
           $urandom_range(0, 3) == 0, $urandom_range(0, 19) == 0,
           10'($urandom), 3'($urandom),
           $urandom_range(0, 199) == 0, $urandom_range(0, 199) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule